// File: doc/BRIEF.md
# Length-Prefixed RGB Plane Loader

This block sits behind a UART receiver and turns a byte stream from a host into a colour image held in three on-chip memories. The stream opens with a two-byte length field that gives the number of pixels to follow. Each pixel then arrives as three bytes: red, then green, then blue. The block writes one byte into each of three separate plane memories, all at the same address.

A down-counter is loaded from the length field and drops by one for each completed pixel. When it reaches zero, a one-cycle done pulse tells a downstream processing stage that the whole image is in memory. After that the block ignores further bytes until it is reset, so only one image is loaded per reset. A length larger than the plane depth is cut to the depth, so a write can never fall outside the memories.

Top module: `img_plane_loader`

## Requirements
- R1: After a synchronous reset, with no bytes offered, no plane write enable and no done pulse is asserted.
- R2: The first two accepted bytes form the pixel count, high byte first. Exactly that many pixel writes follow, provided the count does not exceed DEPTH.
- R3: Within a pixel, the accepted bytes are taken as red, then green, then blue. All three plane write enables rise together, combinationally, in the cycle the blue byte is offered. They carry that blue byte and the stored red and green bytes.
- R4: The first pixel is written at address 0, and each later pixel goes to the previous address plus one. All three planes use the same address.
- R5: Done is a single-cycle pulse. It is high in the cycle that follows the clock edge that accepts the final blue byte.
- R6: A pixel count of zero produces the done pulse in the cycle after the low length byte is accepted, and no plane write at all.
- R7: Once done has pulsed, every later byte is ignored until reset. It causes no write and no further done pulse.
- R8: A pixel count above DEPTH is reduced to DEPTH. Exactly DEPTH pixels are written, at addresses 0 to DEPTH-1, and done follows the last of them.
- R9: A byte is consumed only in a cycle where the byte-valid input is high. Idle cycles between bytes leave the byte position and the address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| red_we | output | 1 | Red plane write enable |
| red_addr | output | ADDR_W | Red plane write address |
| red_data | output | 8 | Red plane write data |
| green_we | output | 1 | Green plane write enable |
| green_addr | output | ADDR_W | Green plane write address |
| green_data | output | 8 | Green plane write data |
| blue_we | output | 1 | Blue plane write enable |
| blue_addr | output | ADDR_W | Blue plane write address |
| blue_data | output | 8 | Blue plane write data |
| img_done | output | 1 | One-cycle pulse when the full image is stored |

## Verification
The bench uses a count of 17, whose high byte is zero. If the two length bytes were swapped, the count would be clamped to the depth instead, so this case shows whether the length order is right. Pixel values differ per colour and per index, which exposes a swapped plane or a skipped address. A stream with an idle cycle before every byte separates valid-gated advance from free-running advance. A zero count, an oversize count followed by surplus pixels, and trailing bytes after a normal image separate correct termination from early, late or repeated done pulses and stray writes.

// File: rtl/img_loader_pkg.sv
package img_loader_pkg;

  localparam int unsigned LEN_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR_HI,
    ST_HDR_LO,
    ST_RED,
    ST_GREEN,
    ST_BLUE,
    ST_DONE
  } load_state_e;

  // byte slots kept by the staging register
  localparam int unsigned SLOT_HI    = 0;
  localparam int unsigned SLOT_RED   = 1;
  localparam int unsigned SLOT_GREEN = 2;
  localparam int unsigned NUM_SLOTS  = 3;

  function automatic logic [LEN_W-1:0] join_len(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] req,
                                                 input int unsigned depth);
    if (32'(req) > depth) return LEN_W'(depth);
    return req;
  endfunction

endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import img_loader_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_valid,
  input  logic                 len_zero,
  input  logic                 last_px,
  output load_state_e          state_o,
  output logic [NUM_SLOTS-1:0] cap_o,
  output logic                 load_o,
  output logic                 commit_o,
  output logic                 done_o
);

  load_state_e st_q, st_d;
  logic        done_q;
  logic        finish;

  always_comb begin
    cap_o             = '0;
    cap_o[SLOT_HI]    = (st_q == ST_HDR_HI) && rx_valid;
    cap_o[SLOT_RED]   = (st_q == ST_RED)    && rx_valid;
    cap_o[SLOT_GREEN] = (st_q == ST_GREEN)  && rx_valid;
    load_o   = (st_q == ST_HDR_LO) && rx_valid && !len_zero;
    commit_o = (st_q == ST_BLUE) && rx_valid;
    finish   = ((st_q == ST_HDR_LO) && rx_valid && len_zero) || (commit_o && last_px);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   st_d = ST_HDR_HI;
      ST_HDR_HI: if (rx_valid) st_d = ST_HDR_LO;
      ST_HDR_LO: if (rx_valid) st_d = len_zero ? ST_DONE : ST_RED;
      ST_RED:    if (rx_valid) st_d = ST_GREEN;
      ST_GREEN:  if (rx_valid) st_d = ST_BLUE;
      ST_BLUE:   if (rx_valid) st_d = last_px ? ST_DONE : ST_RED;
      ST_DONE:   st_d = ST_DONE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= finish;
    end
  end

  assign state_o = st_q;
  assign done_o  = done_q;

endmodule

// File: rtl/px_counter.sv
module px_counter
  import img_loader_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  logic [LEN_W-1:0]  left_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      addr_q <= '0;
    end else if (load) begin
      left_q <= load_val;
      addr_q <= '0;
    end else if (step) begin
      left_q <= left_q - LEN_W'(1);
      addr_q <= addr_q + ADDR_W'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (left_q == LEN_W'(1));

endmodule

// File: rtl/byte_stage.sv
module byte_stage
  import img_loader_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SLOTS-1:0]      cap,
  input  logic [7:0]                din,
  output logic [NUM_SLOTS-1:0][7:0] q_o
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [7:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst)         slot_q <= '0;
      else if (cap[s]) slot_q <= din;
    end
    assign q_o[s] = slot_q;
  end

endmodule

// File: rtl/img_plane_loader.sv
module img_plane_loader
  import img_loader_pkg::*;
#(
  parameter  int unsigned DEPTH  = 10000,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              red_we,
  output logic [ADDR_W-1:0] red_addr,
  output logic [7:0]        red_data,
  output logic              green_we,
  output logic [ADDR_W-1:0] green_addr,
  output logic [7:0]        green_data,
  output logic              blue_we,
  output logic [ADDR_W-1:0] blue_addr,
  output logic [7:0]        blue_data,
  output logic              img_done
);

  load_state_e                state;
  logic [NUM_SLOTS-1:0]       cap;
  logic [NUM_SLOTS-1:0][7:0]  slot_q;
  logic [LEN_W-1:0]           len_eff;
  logic                       len_zero;
  logic                       len_load;
  logic                       px_commit;
  logic                       px_last;
  logic                       image_end;
  logic [ADDR_W-1:0]          wr_addr;

  assign len_eff  = clamp_len(join_len(slot_q[SLOT_HI], rx_byte), DEPTH);
  assign len_zero = (len_eff == '0);

  loader_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .len_zero (len_zero),
    .last_px  (px_last),
    .state_o  (state),
    .cap_o    (cap),
    .load_o   (len_load),
    .commit_o (px_commit),
    .done_o   (image_end)
  );

  px_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (len_load),
    .load_val (len_eff),
    .step     (px_commit),
    .addr_o   (wr_addr),
    .last_o   (px_last)
  );

  byte_stage u_stage (
    .clk (clk),
    .rst (rst),
    .cap (cap),
    .din (rx_byte),
    .q_o (slot_q)
  );

  assign red_we     = px_commit;
  assign green_we   = px_commit;
  assign blue_we    = px_commit;
  assign red_addr   = wr_addr;
  assign green_addr = wr_addr;
  assign blue_addr  = wr_addr;
  assign red_data   = slot_q[SLOT_RED];
  assign green_data = slot_q[SLOT_GREEN];
  assign blue_data  = rx_byte;
  assign img_done   = image_end;

endmodule

// File: rtl/img_loader_checker.sv
module img_loader_checker #(
  parameter  int unsigned DEPTH  = 10000,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              red_we,
  input logic              green_we,
  input logic              blue_we,
  input logic [ADDR_W-1:0] red_addr,
  input logic [ADDR_W-1:0] green_addr,
  input logic [ADDR_W-1:0] blue_addr,
  input logic              img_done
);

  int unsigned next_addr;
  logic        seen_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_addr <= 0;
      seen_done <= 1'b0;
    end else begin
      if (red_we)   next_addr <= next_addr + 1;
      if (img_done) seen_done <= 1'b1;
    end
  end

  assert_write_needs_byte_R3: assert property (@(posedge clk) disable iff (rst)
    red_we |-> rx_valid);

  assert_planes_together_R3: assert property (@(posedge clk) disable iff (rst)
    (red_we == green_we) && (red_we == blue_we));

  assert_same_address_R4: assert property (@(posedge clk) disable iff (rst)
    red_we |-> (red_addr == green_addr) && (red_addr == blue_addr));

  assert_address_sequence_R4: assert property (@(posedge clk) disable iff (rst)
    red_we |-> (32'(red_addr) == next_addr));

  assert_address_in_range_R8: assert property (@(posedge clk) disable iff (rst)
    red_we |-> (32'(red_addr) < DEPTH));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    img_done |=> !img_done);

  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    seen_done |-> (!red_we && !img_done));

endmodule

bind img_plane_loader img_loader_checker #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_valid   (rx_valid),
  .red_we     (red_we),
  .green_we   (green_we),
  .blue_we    (blue_we),
  .red_addr   (red_addr),
  .green_addr (green_addr),
  .blue_addr  (blue_addr),
  .img_done   (img_done)
);

// File: tb/img_plane_loader_bench.sv
`timescale 1ns/1ps
module img_plane_loader_bench;

  localparam int unsigned DEPTH  = 20;
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_byte = '0;
  logic              red_we, green_we, blue_we, img_done;
  logic [ADDR_W-1:0] red_addr, green_addr, blue_addr;
  logic [7:0]        red_data, green_data, blue_data;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  bit prev_done = 1'b0;
  bit finished = 1'b0;
  logic [31:0] sb_q[$];

  always #10 clk = ~clk;

  img_plane_loader #(.DEPTH(DEPTH)) u_img_plane_loader (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .red_we(red_we), .red_addr(red_addr), .red_data(red_data),
    .green_we(green_we), .green_addr(green_addr), .green_data(green_data),
    .blue_we(blue_we), .blue_addr(blue_addr), .blue_data(blue_data),
    .img_done(img_done)
  );

  function automatic logic [7:0] pix_r(int i, int s); return 8'(i * 7 + s * 13 + 1); endfunction
  function automatic logic [7:0] pix_g(int i, int s); return 8'((i * 11) ^ (s * 29 + 5)); endfunction
  function automatic logic [7:0] pix_b(int i, int s); return 8'(255 - i * 3 - s); endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every plane write, tracks done pulses
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (red_we || green_we || blue_we) begin
          check(red_we && green_we && blue_we, "R3", "enables together",
                int'({red_we, green_we, blue_we}), 7);
          if (sb_q.size() == 0) begin
            check(1'b0, "R7", "unexpected write at addr", int'(red_addr), -1);
          end else begin
            logic [31:0] exp_w;
            exp_w = sb_q.pop_front();
            check(32'(red_addr) == 32'(exp_w[31:24]), "R4", "write address",
                  int'(red_addr), int'(exp_w[31:24]));
            check(green_addr == red_addr && blue_addr == red_addr, "R4", "plane addresses",
                  int'(blue_addr), int'(red_addr));
            check({red_data, green_data, blue_data} == exp_w[23:0], "R3", "pixel bytes",
                  int'({red_data, green_data, blue_data}), int'(exp_w[23:0]));
          end
        end
        if (img_done) begin
          done_cnt++;
          if (prev_done) check(1'b0, "R5", "done wider than one cycle", 2, 1);
        end
        prev_done = img_done;
      end else begin
        prev_done = 1'b0;
      end
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    rx_valid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    done_cnt = 0;
    sb_q.delete();
  endtask

  task automatic drive_byte(logic [7:0] b, bit gap);
    if (gap) begin
      @(posedge clk); #2;
      rx_valid = 1'b0;
      rx_byte  = 8'hEE;
    end
    @(posedge clk); #2;
    rx_valid = 1'b1;
    rx_byte  = b;
  endtask

  task automatic send_header(int len);
    drive_byte(8'(len >> 8), 1'b0);
    drive_byte(8'(len), 1'b0);
  endtask

  // driver: pushes expected items for pixels that must be stored
  task automatic send_pixels(int n, int seed, int keep, bit gap);
    for (int i = 0; i < n; i++) begin
      if (i < keep) sb_q.push_back({8'(i), pix_r(i, seed), pix_g(i, seed), pix_b(i, seed)});
      drive_byte(pix_r(i, seed), gap);
      drive_byte(pix_g(i, seed), gap);
      drive_byte(pix_b(i, seed), gap);
    end
  endtask

  // the last offered byte is captured on the next edge; done follows it
  task automatic expect_done(string req);
    @(posedge clk); #2;
    rx_valid = 1'b0;
    @(negedge clk);
    check(img_done == 1'b1, req, "done after final byte", int'(img_done), 1);
    @(negedge clk);
    check(img_done == 1'b0, req, "done one cycle", int'(img_done), 0);
  endtask

  task automatic expect_drained(string req, int done_exp);
    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, req, "pixels left unwritten", sb_q.size(), 0);
    check(done_cnt == done_exp, req, "done pulse count", done_cnt, done_exp);
  endtask

  initial begin
    // R1: reset state
    do_reset();
    repeat (3) @(negedge clk);
    check(red_we == 1'b0, "R1", "write enable after reset", int'(red_we), 0);
    check(img_done == 1'b0, "R1", "done after reset", int'(img_done), 0);

    // R2 R3 R4 R5: count 17 (high byte 0x00; swapped it would clamp to 20)
    send_header(17);
    send_pixels(17, 1, 17, 1'b0);
    expect_done("R5");
    expect_drained("R2", 1);
    // R7: trailing bytes after done
    send_pixels(3, 9, 0, 1'b0);
    @(posedge clk); #2 rx_valid = 1'b0;
    expect_drained("R7", 1);

    // R9: idle cycle before every byte
    do_reset();
    send_header(4);
    send_pixels(4, 2, 4, 1'b1);
    expect_done("R9");
    expect_drained("R9", 1);

    // R6: zero count, then bytes that must be ignored
    do_reset();
    send_header(0);
    expect_done("R6");
    send_pixels(3, 3, 0, 1'b0);
    @(posedge clk); #2 rx_valid = 1'b0;
    expect_drained("R6", 1);

    // R8: count 0x0105 clamped to DEPTH, surplus pixels ignored
    do_reset();
    send_header(16'h0105);
    send_pixels(DEPTH, 4, DEPTH, 1'b0);
    expect_done("R8");
    send_pixels(5, 5, 0, 1'b0);
    @(posedge clk); #2 rx_valid = 1'b0;
    expect_drained("R8", 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule